// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This controller carries out the memory side of a multi-register load or store. The caller presents a base address, a register-selection mask, an addressing mode and three flags (writeback, load versus store, user-bank transfer) together with a one-cycle `start` pulse. The sequencer counts the selected registers and works out the first address from that count. It then issues one word access per selected register, from the lowest register index upward, one handshake per cycle. While it does this it drives the register-file write port (loads) or read index (stores).

When the last access is accepted, the sequencer raises `done` for one cycle. In that cycle it presents the writeback value for the base register, and it flags the two special outcomes of a load that includes the program-counter register: a branch to the loaded value, and, with the user-bank flag, a restore of the saved status word. Decode, the memory and the register file sit outside this block.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset `mem_req`, `done`, `busy`, `branch`, `psr_restore` and `wb_we` are all 0.
- R2: The first access address depends on the mode `am_i` and the selected-register count n. Mode 0 uses base. Mode 1 uses base+4. Mode 2 uses base-4n+4. Mode 3 uses base-4n. Arithmetic is modulo 2^32.
- R3: There is exactly one access per set bit of `reg_list_i`. Accesses go in ascending register index, and each address is 4 above the previous one. `mem_we` is 1 for stores (`is_load_i`=0) and 0 for loads.
- R4: A request that sees `mem_ready`=0 stays asserted with unchanged address and index in the next cycle. A request advances only on a cycle where `mem_ready`=1.
- R5: On an accepted load access, `rf_wr_en` is 1 with `rf_wr_idx` equal to the register index and `rf_wr_data` equal to `mem_rdata`. On a store access, `rf_rd_idx` equals the register index and `mem_wdata` equals `rf_rd_data`.
- R6: `done` is high for exactly one cycle, in the cycle after the last accepted access. In that cycle `wb_we` equals the latched writeback flag. `wb_data` is base+4n for modes 0 and 1 and base-4n for modes 2 and 3.
- R7: An all-zero register list produces no access. `done` rises in the cycle after `start`, and `wb_data` equals base.
- R8: During the accesses, `rf_user_bank` is 1 when the user-bank flag is set, except for a load whose list includes bit 15. That exception gives 0, as does the flag being clear.
- R9: `psr_restore` is 1 in the `done` cycle exactly when the transfer was a load with the user-bank flag set and bit 15 in the list.
- R10: `branch` is 1 in the `done` cycle exactly for a load with bit 15 in the list. `branch_addr` then holds the word loaded for register 15.
- R11: A `start` pulse while `busy` is 1 is ignored. The running transfer keeps its addresses, order and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| base_i | input | 32 | Base register value |
| reg_list_i | input | 16 | Register-selection mask, bit k selects register k |
| am_i | input | 2 | Addressing mode 0..3 (see R2) |
| wb_en_i | input | 1 | Write the new base back at the end |
| is_load_i | input | 1 | 1 = load from memory, 0 = store |
| user_bank_i | input | 1 | User-bank transfer flag |
| mem_req | output | 1 | Access request valid |
| mem_addr | output | 32 | Access word address |
| mem_we | output | 1 | 1 = write access |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| rf_rd_idx | output | 4 | Register read index for stores |
| rf_rd_data | input | 32 | Register read data |
| rf_wr_en | output | 1 | Register write strobe for loads |
| rf_wr_idx | output | 4 | Register write index |
| rf_wr_data | output | 32 | Register write data |
| rf_user_bank | output | 1 | Register accesses target the user bank |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| wb_we | output | 1 | Base writeback strobe (with `done`) |
| wb_data | output | 32 | New base value |
| psr_restore | output | 1 | Copy saved status into current status (with `done`) |
| branch | output | 1 | Program counter was loaded (with `done`) |
| branch_addr | output | 32 | Loaded program-counter value |

## Verification
Every mode is run against a different mask shape: a sparse low mask, a mask with widely spaced bits including bit 15, a contiguous middle run, a full mask whose start address wraps below zero, a single bit, and an empty mask. This separates a wrong count, a wrong start offset and a wrong step direction. Stall patterns on `mem_ready` show that the request holds its address and index and never skips or repeats a register. Loads and stores with bit 15 present or absent, with the user-bank flag on and off, distinguish the four combinations of branch, status restore and bank select. A `start` pulse with a different mask in the middle of a transfer shows that nothing is relatched.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   typedef enum logic [1:0] {
      AM_INC_AFTER  = 2'd0,
      AM_INC_BEFORE = 2'd1,
      AM_DEC_AFTER  = 2'd2,
      AM_DEC_BEFORE = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_DONE = 2'd2
   } xstate_e;

endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
   parameter int NREG  = 16,
   parameter int CNT_W = $clog2(NREG + 1),
   parameter int STYLE = 1
) (
   input  logic [NREG-1:0]  vec,
   output logic [CNT_W-1:0] cnt
);

   generate
      if (CNT_W < $clog2(NREG + 1)) begin : g_bad_w
         $error("blkxfer_popcnt: CNT_W too narrow");
      end
      if (STYLE == 1 && (NREG % 4) != 0) begin : g_bad_style
         $error("blkxfer_popcnt: STYLE 1 needs NREG a multiple of 4");
      end

      if (STYLE == 0) begin : g_linear
         always_comb begin
            cnt = '0;
            for (int i = 0; i < NREG; i++) begin
               cnt = cnt + CNT_W'(vec[i]);
            end
         end
      end else begin : g_nibble
         localparam int NNIB = NREG / 4;
         logic [2:0] nib_sum [NNIB];
         for (genvar g = 0; g < NNIB; g++) begin : g_nib
            assign nib_sum[g] = 3'(vec[4*g]) + 3'(vec[4*g+1])
                              + 3'(vec[4*g+2]) + 3'(vec[4*g+3]);
         end
         always_comb begin
            cnt = '0;
            for (int k = 0; k < NNIB; k++) begin
               cnt = cnt + CNT_W'(nib_sum[k]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/blkxfer_span.sv
module blkxfer_span
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  amode_e            mode,
   input  logic [CNT_W-1:0]  cnt,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] final_base
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   generate
      if (WORD_BYTES < 1) begin : g_bad_word
         $error("blkxfer_span: WORD_BYTES must be positive");
      end
      if (ADDR_W <= CNT_W) begin : g_bad_addr
         $error("blkxfer_span: ADDR_W must exceed CNT_W");
      end
   endgenerate

   logic [ADDR_W-1:0] span;
   assign span = ADDR_W'(cnt) * STEP;

   always_comb begin
      unique case (mode)
         AM_INC_AFTER:  first_addr = base;
         AM_INC_BEFORE: first_addr = base + STEP;
         AM_DEC_AFTER:  first_addr = base - span + STEP;
         default:       first_addr = base - span;
      endcase
      final_base = mode[1] ? (base - span) : (base + span);
   end

endmodule

// File: rtl/blkxfer_lsb.sv
module blkxfer_lsb #(
   parameter int NREG  = 16,
   parameter int IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   generate
      if ((1 << IDX_W) < NREG) begin : g_bad_idx
         $error("blkxfer_lsb: IDX_W too narrow");
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
      any = |vec;
   end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   parameter int CNT_STYLE  = 1,
   parameter int IDX_W      = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [NREG-1:0]   reg_list_i,
   input  logic [1:0]        am_i,
   input  logic              wb_en_i,
   input  logic              is_load_i,
   input  logic              user_bank_i,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [IDX_W-1:0]  rf_rd_idx,
   input  logic [DATA_W-1:0] rf_rd_data,
   output logic              rf_wr_en,
   output logic [IDX_W-1:0]  rf_wr_idx,
   output logic [DATA_W-1:0] rf_wr_data,
   output logic              rf_user_bank,
   output logic              busy,
   output logic              done,
   output logic              wb_we,
   output logic [ADDR_W-1:0] wb_data,
   output logic              psr_restore,
   output logic              branch,
   output logic [DATA_W-1:0] branch_addr
);

   localparam int                CNT_W  = $clog2(NREG + 1);
   localparam int                PC_IDX = NREG - 1;
   localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(WORD_BYTES);

   generate
      if (NREG < 2) begin : g_bad_nreg
         $error("blkxfer_seq: NREG must be at least 2");
      end
      if (DATA_W < ADDR_W) begin : g_bad_data
         $error("blkxfer_seq: DATA_W must hold an address");
      end
   endgenerate

   // count and address span
   logic [CNT_W-1:0]  sel_cnt;
   logic [ADDR_W-1:0] first_addr;
   logic [ADDR_W-1:0] final_base;

   blkxfer_popcnt #(
      .NREG  (NREG),
      .CNT_W (CNT_W),
      .STYLE (CNT_STYLE)
   ) u_cnt (
      .vec (reg_list_i),
      .cnt (sel_cnt)
   );

   blkxfer_span #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_span (
      .base       (base_i),
      .mode       (amode_e'(am_i)),
      .cnt        (sel_cnt),
      .first_addr (first_addr),
      .final_base (final_base)
   );

   // sequencing state
   xstate_e           state_q;
   logic [NREG-1:0]   remain_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] wbv_q;
   logic              ld_q, ub_q, wb_q, pc_in_q;
   logic [DATA_W-1:0] pc_val_q;

   logic [IDX_W-1:0]  cur_idx;
   logic              cur_any;
   logic [NREG-1:0]   cur_oh;
   logic              fire;

   blkxfer_lsb #(
      .NREG  (NREG),
      .IDX_W (IDX_W)
   ) u_pick (
      .vec (remain_q),
      .idx (cur_idx),
      .any (cur_any)
   );

   assign cur_oh = NREG'(1) << cur_idx;
   assign fire   = (state_q == ST_XFER) && cur_any && mem_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         remain_q <= '0;
         addr_q   <= '0;
         wbv_q    <= '0;
         ld_q     <= 1'b0;
         ub_q     <= 1'b0;
         wb_q     <= 1'b0;
         pc_in_q  <= 1'b0;
         pc_val_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  remain_q <= reg_list_i;
                  addr_q   <= first_addr;
                  wbv_q    <= final_base;
                  ld_q     <= is_load_i;
                  ub_q     <= user_bank_i;
                  wb_q     <= wb_en_i;
                  pc_in_q  <= reg_list_i[PC_IDX];
                  state_q  <= (reg_list_i == '0) ? ST_DONE : ST_XFER;
               end
            end
            ST_XFER: begin
               if (fire) begin
                  remain_q <= remain_q & ~cur_oh;
                  addr_q   <= addr_q + STEP;
                  if (ld_q && cur_idx == IDX_W'(PC_IDX)) begin
                     pc_val_q <= mem_rdata;
                  end
                  if (remain_q == cur_oh) begin
                     state_q <= ST_DONE;
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   // outputs
   assign mem_req      = (state_q == ST_XFER) && cur_any;
   assign mem_addr     = addr_q;
   assign mem_we       = ~ld_q;
   assign mem_wdata    = rf_rd_data;
   assign rf_rd_idx    = cur_idx;
   assign rf_wr_en     = fire && ld_q;
   assign rf_wr_idx    = cur_idx;
   assign rf_wr_data   = mem_rdata;
   assign rf_user_bank = ub_q && !(ld_q && pc_in_q);
   assign busy         = (state_q != ST_IDLE);
   assign done         = (state_q == ST_DONE);
   assign wb_we        = done && wb_q;
   assign wb_data      = wbv_q;
   assign psr_restore  = done && ld_q && ub_q && pc_in_q;
   assign branch       = done && ld_q && pc_in_q;
   assign branch_addr  = pc_val_q;

   // assertions
   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !mem_req && !done) // R1
      else $error("request or done during reset");

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(rf_rd_idx)) // R4
      else $error("request dropped or changed while stalled");

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> !mem_req || (mem_addr == $past(mem_addr) + STEP)) // R3
      else $error("address did not advance by one word");

   AST_IDX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> !mem_req || (rf_rd_idx > $past(rf_rd_idx))) // R3
      else $error("register index did not ascend");

   AST_WR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |-> mem_req && mem_ready && !mem_we) // R5
      else $error("register write outside an accepted load");

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) // R6
      else $error("done longer than one cycle");

   AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req) // R6
      else $error("request together with done");

   AST_PSR_IMPLIES_BR: assert property (@(posedge clk) disable iff (!rst_n)
      psr_restore |-> branch) // R9
      else $error("status restore without program-counter load");

   AST_BR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      branch |-> done && !mem_we) // R10
      else $error("branch outside done of a load");

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> $stable(wb_data)) // R11
      else $error("writeback value changed mid transfer");

endmodule

// File: tb/tb_blkxfer_seq.sv
`timescale 1ns/1ps
module tb_blkxfer_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_i = '0;
   logic [15:0] reg_list_i = '0;
   logic [1:0]  am_i = '0;
   logic        wb_en_i = 1'b0, is_load_i = 1'b0, user_bank_i = 1'b0;
   logic        mem_req, mem_we, mem_ready = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
   logic [3:0]  rf_rd_idx, rf_wr_idx;
   logic        rf_wr_en, rf_user_bank, busy, done, wb_we, psr_restore, branch;
   logic [31:0] wb_data, branch_addr;

   localparam logic [31:0] RD_KEY = 32'h5A5A_0000;

   assign mem_rdata  = mem_addr ^ RD_KEY;
   assign rf_rd_data = {16'hC0DE, 12'h000, rf_rd_idx};

   always #5 clk = ~clk;

   blkxfer_seq dut (
      .clk, .rst_n, .start, .base_i, .reg_list_i, .am_i, .wb_en_i, .is_load_i,
      .user_bank_i, .mem_req, .mem_addr, .mem_we, .mem_wdata, .mem_ready,
      .mem_rdata, .rf_rd_idx, .rf_rd_data, .rf_wr_en, .rf_wr_idx, .rf_wr_data,
      .rf_user_bank, .busy, .done, .wb_we, .wb_data, .psr_restore, .branch,
      .branch_addr
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_xfer(input string name, input logic [31:0] base,
                           input logic [15:0] list, input logic [1:0] mode,
                           input bit wb, input bit ld, input bit ub,
                           input logic [7:0] rdy_pat, input bit poke);
      int          exp_idx [16];
      int          n = 0;
      int          acc = 0;
      int          cyc = 0;
      bit          got_done = 0;
      bit          was_stall = 0;
      bit          hold_ok = 1, user_ok = 1, rf_ok = 1;
      bit          stalled_any = 0;
      logic [31:0] first, exp_wb, prev_addr, last_addr;
      logic [3:0]  prev_idx;
      bit          exp_user, exp_br, exp_psr;
      for (int i = 0; i < 16; i++) if (list[i]) begin exp_idx[n] = i; n++; end
      case (mode)
         2'd0: first = base;
         2'd1: first = base + 32'd4;
         2'd2: first = base - 32'(4 * n) + 32'd4;
         default: first = base - 32'(4 * n);
      endcase
      exp_wb   = mode[1] ? base - 32'(4 * n) : base + 32'(4 * n);
      exp_user = ub && !(ld && list[15]);
      exp_br   = ld && list[15];
      exp_psr  = ld && ub && list[15];
      last_addr = '0;
      prev_addr = '0;
      prev_idx  = '0;

      @(negedge clk);
      base_i = base; reg_list_i = list; am_i = mode;
      wb_en_i = wb; is_load_i = ld; user_bank_i = ub; start = 1'b1;
      while (!got_done && cyc < 300) begin
         @(negedge clk);
         start = 1'b0;
         if (poke && cyc == 1) begin
            start = 1'b1; reg_list_i = 16'hFFFF; base_i = 32'hDEAD_0000;
            am_i = 2'd3; is_load_i = ~ld;
         end else if (poke && cyc == 2) begin
            base_i = base; reg_list_i = list; am_i = mode; is_load_i = ld;
         end
         mem_ready = rdy_pat[cyc % 8];
         #1;
         if (was_stall) begin
            if (!(mem_req && mem_addr == prev_addr && rf_rd_idx == prev_idx))
               hold_ok = 0;
         end
         was_stall = mem_req && !mem_ready;
         if (was_stall) stalled_any = 1;
         prev_addr = mem_addr;
         prev_idx  = rf_rd_idx;
         if (mem_req && rf_user_bank !== exp_user) user_ok = 0;
         if (mem_req && mem_ready) begin
            if (acc < n) begin
               logic [31:0] ea;
               ea = first + 32'(4 * acc);
               if (acc == 0)
                  chk(mem_addr == first, "R2", {name, " first address"}, mem_addr, first);
               chk(mem_addr == ea && rf_rd_idx == 4'(exp_idx[acc]) && mem_we == !ld,
                   "R3", {name, " access addr/idx/we"},
                   {mem_addr[27:0], rf_rd_idx}, {ea[27:0], 4'(exp_idx[acc])});
               if (ld) begin
                  if (!(rf_wr_en && rf_wr_idx == 4'(exp_idx[acc]) &&
                        rf_wr_data == (ea ^ RD_KEY))) rf_ok = 0;
               end else begin
                  if (!(!rf_wr_en && mem_wdata == {16'hC0DE, 12'h000, 4'(exp_idx[acc])}))
                     rf_ok = 0;
               end
               last_addr = ea;
            end
            acc++;
         end
         if (done) begin
            got_done = 1;
            chk(wb_we == wb && wb_data == exp_wb, "R6", {name, " writeback"},
                {wb_data[30:0], wb_we}, {exp_wb[30:0], wb});
            chk(psr_restore == exp_psr, "R9", {name, " status restore"},
                32'(psr_restore), 32'(exp_psr));
            chk(branch == exp_br, "R10", {name, " branch flag"}, 32'(branch), 32'(exp_br));
            if (exp_br)
               chk(branch_addr == (last_addr ^ RD_KEY), "R10", {name, " branch target"},
                   branch_addr, last_addr ^ RD_KEY);
            if (n == 0)
               chk(cyc == 0 && acc == 0, "R7", {name, " empty list done timing"},
                   32'(cyc), 32'd0);
         end
         cyc++;
      end
      mem_ready = 1'b0;
      chk(got_done, "R6", {name, " done seen"}, 32'(got_done), 32'd1);
      chk(acc == n, poke ? "R11" : "R3", {name, " access count"}, 32'(acc), 32'(n));
      if (n > 0) chk(rf_ok, "R5", {name, " register port"}, 32'(rf_ok), 32'd1);
      if (n > 0) chk(user_ok, "R8", {name, " user bank select"}, 32'(user_ok), 32'd1);
      if (stalled_any) chk(hold_ok, "R4", {name, " stall hold"}, 32'(hold_ok), 32'd1);
      @(negedge clk); #1;
      chk(!done && !busy, "R6", {name, " done single cycle"}, {30'd0, done, busy}, 32'd0);
   endtask

   task automatic check_reset();
      #1;
      chk(!mem_req && !done && !busy && !branch && !psr_restore && !wb_we, "R1",
          "reset outputs",
          {26'd0, mem_req, done, busy, branch, psr_restore, wb_we}, 32'd0);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_reset();
      rst_n = 1'b1;
      // name, base, list, mode, wb, ld, ub, ready pattern, poke
      run_xfer("ia_load",       32'h0000_1000, 16'h00F3, 2'd0, 1, 1, 0, 8'hFF, 0);
      run_xfer("ib_store_stall",32'h0000_2000, 16'h8421, 2'd1, 1, 0, 0, 8'b1001_0110, 0);
      run_xfer("da_load",       32'h0000_3000, 16'h0FF0, 2'd2, 0, 1, 0, 8'b1010_1010, 0);
      run_xfer("db_store_wrap", 32'h0000_0020, 16'hFFFF, 2'd3, 1, 0, 0, 8'hFF, 0);
      run_xfer("empty",         32'h0000_4000, 16'h0000, 2'd1, 1, 1, 0, 8'hFF, 0);
      run_xfer("ld_pc_user",    32'h0000_5000, 16'h8003, 2'd0, 0, 1, 1, 8'b1101_1011, 0);
      run_xfer("ld_user",       32'h0000_6000, 16'h0006, 2'd3, 1, 1, 1, 8'hFF, 0);
      run_xfer("st_pc_user",    32'h0000_7000, 16'h8001, 2'd1, 0, 0, 1, 8'hFF, 0);
      run_xfer("ld_pc_only",    32'h0000_8000, 16'h8000, 2'd2, 1, 1, 0, 8'b0110_0110, 0);
      run_xfer("busy_start",    32'h0000_9000, 16'h0155, 2'd0, 1, 1, 0, 8'b0111_0111, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule